// File: doc/BRIEF.md
# Regulator Fault Supervisor with Hiccup Restart

This block sits beside a power sequencer and turns already-digitized fault flags into a shutdown decision. It sees per-rail undervoltage and overvoltage flags, an overcurrent flag from the switching stage and an overtemperature flag. It also sees the present sleep state (active or suspend-to-RAM). From these it drives one kill line that turns every regulator off. It sorts faults into two groups. Recoverable faults (undervoltage, overcurrent) get a timed hiccup. Destructive faults (overvoltage, overtemperature) latch the outputs off.

In a hiccup the kill line is held for three full soft-start periods, each counted in oscillator ticks. Then a single-cycle restart request asks the sequencer for a normal ramp. If the fault is still there after that ramp starts, the cycle repeats with no limit. A latched fault holds until a fresh power-on reset or a rising edge of the S5 request. A thermal latch additionally needs the junction cool flag at the moment of that clear event.

Top module: `reg_fault_supervisor`

## Requirements
- R1: After reset, kill_o, restart_o, latched_o and latch_thermal_o are all low.
- R2: With s0_i high and no fault held, oc_i high or any uv_i bit high sets kill_o on the next clock edge, with latched_o staying low.
- R3: A hiccup keeps kill_o high for exactly BLANK_PERIODS x TICKS_PER_SS (default 3 x 2048) cycles with tick_i high. On the edge that counts the last tick, restart_o goes high for exactly one cycle and kill_o falls.
- R4: If the recoverable fault is still present after the restart, kill_o is low for exactly one cycle and then a new hiccup begins.
- R5: While ss_busy_i is high, uv_i is ignored, but oc_i still trips.
- R6: With s0_i high, any ov_i bit sets latched_o and kill_o on the next edge. latched_o then stays high and restart_o is never raised while latched_o is high.
- R7: A latched fault clears on the edge where por_i is high, or on the edge where s5_on_i is high after having been low on the previous edge. Without either event it holds indefinitely.
- R8: hot_i, sampled while s0_i or s3_i is high, sets latched_o and latch_thermal_o. A thermal latch clears only when cool_i is high during a clear event from R7.
- R9: uv_i, ov_i and oc_i have no effect while s0_i is low. hot_i has no effect while both s0_i and s3_i are low.
- R10: An overvoltage that arrives in the same cycle as a recoverable fault, or during a hiccup, wins. The latch is set, any hiccup in progress is abandoned, and no restart is requested.
- R11: Blanking time advances only on cycles with tick_i high. With tick_i held low, kill_o stays high and no restart occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| s0_i | input | 1 | System in active state; enables rail monitoring |
| s3_i | input | 1 | System in suspend-to-RAM state |
| s5_on_i | input | 1 | S5 request, high when not in soft-off |
| por_i | input | 1 | Fresh power-on reset event, clears latch |
| tick_i | input | 1 | Oscillator tick enable for soft-start timing |
| ss_busy_i | input | 1 | Soft-start ramp in progress |
| uv_i | input | N_RAILS | Per-rail undervoltage flags |
| ov_i | input | N_RAILS | Per-rail overvoltage flags |
| oc_i | input | 1 | Switcher overcurrent flag |
| hot_i | input | 1 | Junction over-temperature flag |
| cool_i | input | 1 | Junction below release temperature |
| kill_o | output | 1 | Disable all regulators |
| restart_o | output | 1 | One-cycle soft-start restart request |
| latched_o | output | 1 | Latched fault status |
| latch_thermal_o | output | 1 | Latched fault includes over-temperature |

## Verification
A table of single-cycle flag patterns is used, with reset applied between rows. Each pattern is a state and flag combination. The rows separate trips that only kill from trips that latch and from flags that must be ignored: undervoltage during a ramp, rail faults outside the active state, overvoltage in suspend. Directed sequences then measure the blanking length down to the exact cycle, with ticks both running and stalled. They also check that a held fault gives a one-cycle gap and a second hiccup. The remaining sequences cover each latch-clear path, with and without the cool flag, and an overvoltage arriving mid-hiccup, where the absence of any later restart pulse shows the latch took priority.

// File: rtl/reg_sup_pkg.sv
package reg_sup_pkg;
  typedef struct packed {
    logic uv;
    logic oc;
    logic ov;
    logic hot;
  } fault_hits_t;
endpackage

// File: rtl/fault_classifier.sv
module fault_classifier
  import reg_sup_pkg::*;
#(
  parameter int N_RAILS = 3
) (
  input  logic               s0_i,
  input  logic               s3_i,
  input  logic               ss_busy_i,
  input  logic [N_RAILS-1:0] uv_i,
  input  logic [N_RAILS-1:0] ov_i,
  input  logic               oc_i,
  input  logic               hot_i,
  output fault_hits_t        hits_o
);
  always_comb begin
    hits_o.uv  = s0_i && !ss_busy_i && (|uv_i);
    hits_o.oc  = s0_i && oc_i;
    hits_o.ov  = s0_i && (|ov_i);
    hits_o.hot = (s0_i || s3_i) && hot_i;
  end
endmodule

// File: rtl/fault_latch.sv
module fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_ov_i,
  input  logic set_hot_i,
  input  logic por_i,
  input  logic s5_on_i,
  input  logic cool_i,
  output logic latched_o,
  output logic thermal_o
);
  logic s5_q;
  logic s5_rise;
  logic clr_ok;
  logic set_any;

  assign s5_rise = s5_on_i && !s5_q;
  assign clr_ok  = (por_i || s5_rise) && (!thermal_o || cool_i);
  assign set_any = set_ov_i || set_hot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s5_q      <= 1'b1;
      latched_o <= 1'b0;
      thermal_o <= 1'b0;
    end else begin
      s5_q <= s5_on_i;
      if (set_any) begin
        latched_o <= 1'b1;
        thermal_o <= set_hot_i || (thermal_o && !clr_ok);
      end else if (latched_o && clr_ok) begin
        latched_o <= 1'b0;
        thermal_o <= 1'b0;
      end
    end
  end

  // R7: no clear event, no release
  a_r7_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_o && !por_i && !(s5_on_i && !s5_q)) |=> latched_o);
  // R8: thermal latch survives while still warm
  a_r8_cool_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_o && thermal_o && !cool_i) |=> latched_o);
  a_r8_thermal_implies_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thermal_o |-> latched_o);
endmodule

// File: rtl/hiccup_timer.sv
module hiccup_timer #(
  parameter int TICKS_PER_SS  = 2048,
  parameter int BLANK_PERIODS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic abort_i,
  input  logic tick_i,
  output logic active_o,
  output logic restart_o
);
  localparam int CNT_W = (TICKS_PER_SS > 1) ? $clog2(TICKS_PER_SS) : 1;
  localparam int PER_W = (BLANK_PERIODS > 1) ? $clog2(BLANK_PERIODS) : 1;
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TICKS_PER_SS - 1);
  localparam logic [PER_W-1:0] LAST_PER  = PER_W'(BLANK_PERIODS - 1);

  logic [CNT_W-1:0] tick_cnt;
  logic [PER_W-1:0] per_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o  <= 1'b0;
      restart_o <= 1'b0;
      tick_cnt  <= '0;
      per_cnt   <= '0;
    end else begin
      restart_o <= 1'b0;
      if (abort_i) begin
        active_o <= 1'b0;
      end else if (!active_o && trip_i) begin
        active_o <= 1'b1;
        tick_cnt <= '0;
        per_cnt  <= '0;
      end else if (active_o && tick_i) begin
        if (tick_cnt == LAST_TICK) begin
          tick_cnt <= '0;
          if (per_cnt == LAST_PER) begin
            active_o  <= 1'b0;
            restart_o <= 1'b1;
          end else begin
            per_cnt <= per_cnt + 1'b1;
          end
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end

  a_r3_period_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_cnt <= LAST_PER);
  a_r3_restart_ends_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> (!active_o && $past(active_o)));
  a_r11_no_tick_no_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !tick_i && !abort_i) |=> (active_o && $stable(tick_cnt) && !restart_o));
  a_r10_abort_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!active_o && !restart_o));
endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor
  import reg_sup_pkg::*;
#(
  parameter int N_RAILS       = 3,
  parameter int TICKS_PER_SS  = 2048,
  parameter int BLANK_PERIODS = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               s0_i,
  input  logic               s3_i,
  input  logic               s5_on_i,
  input  logic               por_i,
  input  logic               tick_i,
  input  logic               ss_busy_i,
  input  logic [N_RAILS-1:0] uv_i,
  input  logic [N_RAILS-1:0] ov_i,
  input  logic               oc_i,
  input  logic               hot_i,
  input  logic               cool_i,
  output logic               kill_o,
  output logic               restart_o,
  output logic               latched_o,
  output logic               latch_thermal_o
);
  fault_hits_t hits;
  logic set_latch;
  logic trip;
  logic abort;
  logic hic_active;

  fault_classifier #(.N_RAILS(N_RAILS)) u_class (
    .s0_i      (s0_i),
    .s3_i      (s3_i),
    .ss_busy_i (ss_busy_i),
    .uv_i      (uv_i),
    .ov_i      (ov_i),
    .oc_i      (oc_i),
    .hot_i     (hot_i),
    .hits_o    (hits)
  );

  assign set_latch = hits.ov || hits.hot;
  assign abort     = set_latch || latched_o;
  assign trip      = hits.uv || hits.oc;

  fault_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_ov_i  (hits.ov),
    .set_hot_i (hits.hot),
    .por_i     (por_i),
    .s5_on_i   (s5_on_i),
    .cool_i    (cool_i),
    .latched_o (latched_o),
    .thermal_o (latch_thermal_o)
  );

  hiccup_timer #(
    .TICKS_PER_SS  (TICKS_PER_SS),
    .BLANK_PERIODS (BLANK_PERIODS)
  ) u_hiccup (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trip_i    (trip),
    .abort_i   (abort),
    .tick_i    (tick_i),
    .active_o  (hic_active),
    .restart_o (restart_o)
  );

  assign kill_o = latched_o || hic_active;

  a_r2_oc_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s0_i && oc_i && !kill_o) |=> kill_o);
  a_r6_ov_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s0_i && (|ov_i)) |=> (latched_o && kill_o));
  a_r6_no_restart_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o |-> !restart_o);
  a_r3_restart_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);
  a_r9_idle_no_kill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s0_i && !s3_i && !kill_o) |=> !kill_o);
endmodule

// File: tb/reg_fault_supervisor_test.sv
module reg_fault_supervisor_test;
  localparam int TICKS = 2048;
  localparam int BLANK = 3;
  localparam int HOLD  = TICKS * BLANK;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic s0, s3, s5_on, por, tick, busy, oc, hot, cool;
  logic [2:0] uv, ov;
  logic kill, restart, latched, lat_th;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int restart_cnt = 0;

  always #4 clk = ~clk;

  reg_fault_supervisor #(.N_RAILS(3), .TICKS_PER_SS(TICKS), .BLANK_PERIODS(BLANK)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .s0_i(s0), .s3_i(s3), .s5_on_i(s5_on), .por_i(por),
    .tick_i(tick), .ss_busy_i(busy), .uv_i(uv), .ov_i(ov), .oc_i(oc), .hot_i(hot),
    .cool_i(cool), .kill_o(kill), .restart_o(restart), .latched_o(latched),
    .latch_thermal_o(lat_th)
  );

  always @(negedge clk) if (rst_ni && restart) restart_cnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // [17:14] req, s0, s3, busy, uv[3], ov[3], oc, hot, exp kill, exp latched, exp thermal
  localparam logic [17:0] VEC [10] = '{
    18'b0010_1_0_0_000_000_1_0_100,  // R2 oc
    18'b0010_1_0_0_010_000_0_0_100,  // R2 uv
    18'b0101_1_0_1_100_000_0_0_000,  // R5 uv during ramp
    18'b0101_1_0_1_000_000_1_0_100,  // R5 oc during ramp
    18'b0110_1_0_0_000_001_0_0_110,  // R6 ov
    18'b1001_0_1_0_000_111_0_0_000,  // R9 ov in suspend
    18'b1000_0_1_0_000_000_0_1_111,  // R8 hot in suspend
    18'b1001_0_0_0_111_000_1_0_000,  // R9 no state
    18'b1010_1_0_0_001_100_0_0_110,  // R10 ov with uv
    18'b1000_1_0_0_000_000_0_1_111   // R8 hot active
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    s0 = 0; s3 = 0; s5_on = 1; por = 0; tick = 1; busy = 0;
    oc = 0; hot = 0; cool = 0; uv = '0; ov = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_ni = 0;
    step(2);
    rst_ni = 1;
    step(1);
  endtask

  initial begin
    int rc;
    idle_inputs();
    step(2);
    rst_ni = 1;
    step(1);
    // R1 reset state
    chk(kill == 0, "R1", "kill", kill, 0);
    chk(restart == 0, "R1", "restart", restart, 0);
    chk(latched == 0 && lat_th == 0, "R1", "latched", latched, 0);

    for (int i = 0; i < 10; i++) begin
      logic [17:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d row%0d", v[17:14], i);
      do_reset();
      s0 = v[13]; s3 = v[12]; busy = v[11]; uv = v[10:8]; ov = v[7:5];
      oc = v[4]; hot = v[3];
      step(1);
      chk(kill == v[2], tag, "kill", kill, v[2]);
      chk(latched == v[1], tag, "latched", latched, v[1]);
      chk(lat_th == v[0], tag, "thermal", lat_th, v[0]);
    end

    // R3 exact blanking length
    do_reset();
    s0 = 1; oc = 1;
    step(1);
    oc = 0;
    chk(kill == 1, "R3", "kill at trip", kill, 1);
    step(HOLD - 1);
    chk(kill == 1 && restart == 0, "R3", "kill before end", kill, 1);
    step(1);
    chk(restart == 1, "R3", "restart pulse", restart, 1);
    chk(kill == 0, "R3", "kill released", kill, 0);
    step(1);
    chk(restart == 0, "R3", "pulse width", restart, 0);

    // R4 persistent fault repeats
    do_reset();
    s0 = 1; uv = 3'b001;
    step(1);
    step(HOLD - 1);
    step(1);
    chk(restart == 1 && kill == 0, "R4", "first restart", kill, 0);
    step(1);
    chk(kill == 1 && restart == 0, "R4", "second hiccup", kill, 1);

    // R11 ticks stalled
    do_reset();
    s0 = 1; tick = 0; oc = 1;
    step(1);
    oc = 0;
    rc = restart_cnt;
    step(10000);
    chk(kill == 1, "R11", "kill while stalled", kill, 1);
    chk(restart_cnt == rc, "R11", "no restart stalled", restart_cnt - rc, 0);
    tick = 1;
    step(HOLD - 1);
    chk(kill == 1, "R11", "kill after resume", kill, 1);
    step(1);
    chk(restart == 1, "R11", "restart after resume", restart, 1);

    // R7 overvoltage clears
    do_reset();
    s0 = 1; ov = 3'b010;
    step(1);
    ov = 0;
    step(50);
    chk(latched == 1 && kill == 1, "R7", "hold w/o event", latched, 1);
    s5_on = 0;
    step(5);
    chk(latched == 1, "R7", "hold while s5 low", latched, 1);
    s5_on = 1;
    step(1);
    chk(latched == 0 && kill == 0, "R7", "clear on s5 rise", latched, 0);
    ov = 3'b100;
    step(1);
    ov = 0;
    chk(latched == 1, "R6", "relatch", latched, 1);
    por = 1;
    step(1);
    por = 0;
    chk(latched == 0, "R7", "clear on por", latched, 0);

    // R8 thermal clear needs cool
    do_reset();
    s3 = 1; hot = 1;
    step(1);
    hot = 0; cool = 0;
    chk(latched == 1 && lat_th == 1, "R8", "thermal set", lat_th, 1);
    s5_on = 0; step(1); s5_on = 1; step(1);
    chk(latched == 1, "R8", "toggle while warm", latched, 1);
    cool = 1;
    step(3);
    chk(latched == 1, "R8", "cool without event", latched, 1);
    por = 1;
    step(1);
    por = 0;
    chk(latched == 0 && lat_th == 0, "R8", "cool plus por", latched, 0);

    // R10 overvoltage aborts hiccup
    do_reset();
    s0 = 1; oc = 1;
    step(1);
    oc = 0;
    rc = restart_cnt;
    step(100);
    ov = 3'b001;
    step(1);
    ov = 0;
    chk(latched == 1, "R10", "latch mid hiccup", latched, 1);
    step(HOLD + 100);
    chk(restart_cnt == rc, "R10", "no restart", restart_cnt - rc, 0);
    chk(kill == 1, "R10", "kill held", kill, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule